// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects six interrupt sources for a small 8-bit controller core. It masks them, resolves their priority and presents a single request to the CPU together with the index of the winning source. The sources are:

- an external active-low pin;
- two timer overflow pulses;
- a shared slot that is the OR of seven monitor events;
- a serial-port request;
- a display-data-channel I2C request.

Software programs three things through write strobes: an enable register, a priority register and the trigger type of the external pin. The CPU confirms that it has taken the presented request with an acknowledge pulse. It ends a handler with a return strobe.

Internally the block latches the external pin after synchronising it. It can treat the pin as a falling-edge event or follow its level. It latches the timer overflow pulses into flags. It tracks which priority levels are in service, so that a high-priority request can interrupt a low-priority handler but nothing can interrupt a high-priority one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, priority and trigger-type registers are 0, `irqReq` is 0 and `inService` is 2'b00.
- R2: When bit 7 of the enable register (global enable) is 0, `irqReq` stays 0 whatever is pending.
- R3: A source requests only if its enable bit is 1. Enable bits: 0 external pin, 1 timer 0, 2 shared monitor group, 3 timer 1, 4 serial, 5 I2C. Bit 6 has no effect. `irqIdx` carries the same numbers.
- R4: A priority bit at the same position set to 1 puts that source at the high level. An eligible high-level source wins over every low-level source.
- R5: Within one level the lowest index wins (0 first, 5 last).
- R6: With the trigger type set to 1 (falling edge), a falling edge on `extPinN` sets a flag. The flag holds after the pin returns high. An acknowledge of index 0 clears it.
- R7: With the trigger type set to 0 (low level), the flag follows the synchronised inverse of the pin. An acknowledge does not clear it.
- R8: A one-cycle pulse on `tmr0Ovf` or `tmr1Ovf` sets a flag, which holds until an acknowledge of index 1 or 3 clears it.
- R9: The shared slot (index 2) requests while any of the seven `monEvt` bits is 1.
- R10: An acknowledge marks the presented level in service (`inService[1]` high, `inService[0]` low). While low is in service only high-level requests are presented. While high is in service none are.
- R11: A `reti` pulse clears the high in-service bit if it is set, otherwise the low one.
- R12: The external pin reaches `irqReq` on the third clock edge after it changes. Timer pulses reach it one edge after the pulse. The level sources and the register contents act on `irqReq` and `irqIdx` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEnable | input | 1 | Write strobe for the enable register |
| wrPriority | input | 1 | Write strobe for the priority register |
| wrTrigType | input | 1 | Write strobe for the trigger type (takes `wrData[0]`) |
| wrData | input | 8 | Write data |
| extPinN | input | 1 | External interrupt pin, active low, asynchronous |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| monEvt | input | 7 | Monitor event requests sharing slot 2 |
| serReq | input | 1 | Serial-port request level |
| ddcReq | input | 1 | I2C request level |
| irqAck | input | 1 | CPU takes the presented request |
| reti | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqIdx | output | 3 | Index of the presented source |
| inService | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The resolution result is combinational, so table entries and level-source tests are sampled on the falling edge that follows a register write. That write takes effect on the rising edge just before the sample. A timer pulse driven for one cycle is checked one falling edge after the rising edge that latches it. The external pin is checked twice: after two rising edges, when the request must still be absent, and after the third, when it must be present. This pins the synchroniser depth exactly. Acknowledge and return strobes are held across one rising edge, and `inService` and the request are read on the next falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_N = 6;
  localparam int unsigned IDX_W = $clog2(SRC_N);
  localparam int unsigned REG_W = 8;
  localparam int unsigned GLOBAL_BIT = 7;

  localparam logic [IDX_W-1:0] IDX_EXT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_TMR0 = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TMR1 = IDX_W'(3);

  // Writable bits of the two mask registers: bit 6 is reserved.
  localparam logic [REG_W-1:0] EN_MASK = 8'hBF;
  localparam logic [REG_W-1:0] PR_MASK = 8'h3F;

  typedef struct packed {
    logic clrExt;
    logic clrTmr0;
    logic clrTmr1;
  } flagClr_t;

  function automatic logic [IDX_W-1:0] firstSet(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int unsigned MON_EVT_N   = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEnable,
  input  logic                 wrPriority,
  input  logic                 wrTrigType,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 extPinN,
  input  logic                 tmr0Ovf,
  input  logic                 tmr1Ovf,
  input  logic [MON_EVT_N-1:0] monEvt,
  input  logic                 serReq,
  input  logic                 ddcReq,
  input  flagClr_t             strb,
  output logic [SRC_N-1:0]     pendVec,
  output logic [REG_W-1:0]     enReg,
  output logic [REG_W-1:0]     prReg,
  output logic                 edgeMode
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinS, pinPrev, extFlag, tmr0Flag, tmr1Flag;

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      prReg    <= '0;
      edgeMode <= 1'b0;
    end else begin
      if (wrEnable)   enReg    <= wrData & EN_MASK;
      if (wrPriority) prReg    <= wrData & PR_MASK;
      if (wrTrigType) edgeMode <= wrData[0];
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extPinN};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= extPinN;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev  <= 1'b1;
      extFlag  <= 1'b0;
      tmr0Flag <= 1'b0;
      tmr1Flag <= 1'b0;
    end else begin
      pinPrev <= pinS;
      if (edgeMode) begin
        if (pinPrev && !pinS) extFlag <= 1'b1;
        else if (strb.clrExt) extFlag <= 1'b0;
      end else begin
        extFlag <= !pinS;
      end
      if (tmr0Ovf)           tmr0Flag <= 1'b1;
      else if (strb.clrTmr0) tmr0Flag <= 1'b0;
      if (tmr1Ovf)           tmr1Flag <= 1'b1;
      else if (strb.clrTmr1) tmr1Flag <= 1'b0;
    end
  end

  assign pendVec = {ddcReq, serReq, tmr1Flag, |monEvt, tmr0Flag, extFlag};
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] pendVec,
  input  logic [REG_W-1:0] enReg,
  input  logic [REG_W-1:0] prReg,
  input  logic             edgeMode,
  input  logic             irqAck,
  input  logic             reti,
  output logic             irqReq,
  output logic [IDX_W-1:0] irqIdx,
  output logic [1:0]       inService,
  output flagClr_t         strb
);
  logic [SRC_N-1:0] elig, hiSet, loSet;
  logic             reqLevel, take;
  logic [1:0]       svcNext;

  assign elig  = pendVec & enReg[SRC_N-1:0] & {SRC_N{enReg[GLOBAL_BIT]}};
  assign hiSet = elig & prReg[SRC_N-1:0];
  assign loSet = elig & ~prReg[SRC_N-1:0];

  always_comb begin
    irqReq   = 1'b0;
    irqIdx   = '0;
    reqLevel = 1'b0;
    if (|hiSet && !inService[1]) begin
      irqReq   = 1'b1;
      irqIdx   = firstSet(hiSet);
      reqLevel = 1'b1;
    end else if (|loSet && inService == 2'b00) begin
      irqReq = 1'b1;
      irqIdx = firstSet(loSet);
    end
  end

  assign take         = irqAck && irqReq;
  assign strb.clrExt  = take && edgeMode && (irqIdx == IDX_EXT);
  assign strb.clrTmr0 = take && (irqIdx == IDX_TMR0);
  assign strb.clrTmr1 = take && (irqIdx == IDX_TMR1);

  always_comb begin
    svcNext = inService;
    if (reti) begin
      if (svcNext[1]) svcNext[1] = 1'b0;
      else            svcNext[0] = 1'b0;
    end
    if (take) svcNext[reqLevel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) inService <= 2'b00;
    else       inService <= svcNext;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned MON_EVT_N   = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEnable,
  input  logic                 wrPriority,
  input  logic                 wrTrigType,
  input  logic [7:0]           wrData,
  input  logic                 extPinN,
  input  logic                 tmr0Ovf,
  input  logic                 tmr1Ovf,
  input  logic [MON_EVT_N-1:0] monEvt,
  input  logic                 serReq,
  input  logic                 ddcReq,
  input  logic                 irqAck,
  input  logic                 reti,
  output logic                 irqReq,
  output logic [2:0]           irqIdx,
  output logic [1:0]           inService
);
  logic [SRC_N-1:0] pendVec;
  logic [REG_W-1:0] enReg, prReg;
  logic             edgeMode;
  flagClr_t         strb;

  irq_datapath #(.MON_EVT_N(MON_EVT_N), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .wrEnable(wrEnable), .wrPriority(wrPriority),
    .wrTrigType(wrTrigType), .wrData(wrData), .extPinN(extPinN),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .monEvt(monEvt), .serReq(serReq),
    .ddcReq(ddcReq), .strb(strb), .pendVec(pendVec), .enReg(enReg),
    .prReg(prReg), .edgeMode(edgeMode)
  );

  irq_control ctl_i (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enReg(enReg), .prReg(prReg),
    .edgeMode(edgeMode), .irqAck(irqAck), .reti(reti), .irqReq(irqReq),
    .irqIdx(irqIdx), .inService(inService), .strb(strb)
  );
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       irqReq,
  input logic [2:0] irqIdx,
  input logic [1:0] inService,
  input logic       irqAck,
  input logic       reti,
  input logic       tmr0Ovf,
  input logic [7:0] enReg,
  input logic [7:0] prReg,
  input logic [5:0] pendVec
);
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !enReg[7] |-> !irqReq);

  a_r3_enabled_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enReg[irqIdx] && pendVec[irqIdx]));

  a_r4_high_wins: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !inService[1] && |(pendVec & enReg[5:0] & prReg[5:0])) |-> prReg[irqIdx]);

  a_r8_tmr0_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck && irqIdx == 3'd1 && !tmr0Ovf) |=> !pendVec[1]);

  a_r10_high_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    inService[1] |-> !irqReq);

  a_r11_reti_release: assert property (@(posedge clk) disable iff (!rstN)
    (reti && inService[1]) |=> !inService[1]);
endmodule

bind prio_irq_ctrl irq_ctrl_checker chk_i (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqIdx(irqIdx),
  .inService(inService), .irqAck(irqAck), .reti(reti), .tmr0Ovf(tmr0Ovf),
  .enReg(enReg), .prReg(prReg), .pendVec(pendVec)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnable = 0, wrPriority = 0, wrTrigType = 0;
  logic [7:0] wrData = '0;
  logic extPinN = 1'b1, tmr0Ovf = 0, tmr1Ovf = 0;
  logic [6:0] monEvt = '0;
  logic serReq = 0, ddcReq = 0, irqAck = 0, reti = 0;
  logic irqReq;
  logic [2:0] irqIdx;
  logic [1:0] inService;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEnable(wrEnable), .wrPriority(wrPriority),
    .wrTrigType(wrTrigType), .wrData(wrData), .extPinN(extPinN),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .monEvt(monEvt), .serReq(serReq),
    .ddcReq(ddcReq), .irqAck(irqAck), .reti(reti), .irqReq(irqReq),
    .irqIdx(irqIdx), .inService(inService)
  );

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] pr;
    logic [6:0] mon;
    logic       ser;
    logic       ddc;
    logic       expReq;
    logic [2:0] expIdx;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h34, 8'h00, 7'h01, 1'b1, 1'b1, 1'b0, 3'd0},  // R2 global off
    '{8'hB4, 8'h00, 7'h01, 1'b1, 1'b1, 1'b1, 3'd2},  // R5 lowest index
    '{8'hB0, 8'h00, 7'h01, 1'b1, 1'b1, 1'b1, 3'd4},  // R3 group masked
    '{8'hB4, 8'h20, 7'h01, 1'b1, 1'b1, 1'b1, 3'd5},  // R4 high beats low
    '{8'hB4, 8'h30, 7'h01, 1'b1, 1'b1, 1'b1, 3'd4},  // R5 order in high
    '{8'h84, 8'h00, 7'h40, 1'b0, 1'b0, 1'b1, 3'd2},  // R9 top event
    '{8'h84, 8'h00, 7'h01, 1'b0, 1'b0, 1'b1, 3'd2},  // R9 bottom event
    '{8'h84, 8'h00, 7'h00, 1'b1, 1'b1, 1'b0, 3'd0},  // R3 only group enabled
    '{8'hA0, 8'h00, 7'h00, 1'b1, 1'b1, 1'b1, 3'd5},  // R3 single enable
    '{8'hC0, 8'h00, 7'h7F, 1'b1, 1'b1, 1'b0, 3'd0}   // R3 bit 6 has no effect
  };

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkReq(input string tag, input logic r, input logic [2:0] i);
    chk({tag, " req"}, int'(irqReq), int'(r));
    if (r) chk({tag, " idx"}, int'(irqIdx), int'(i));
  endtask

  task automatic wrReg(input int which, input logic [7:0] d);
    wrData = d;
    wrEnable = (which == 0);
    wrPriority = (which == 1);
    wrTrigType = (which == 2);
    tick();
    wrEnable = 0; wrPriority = 0; wrTrigType = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) irqAck = 1'b1;
    else reti = 1'b1;
    tick();
    irqAck = 1'b0;
    reti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(2);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state: everything pending but registers zero
    serReq = 1; ddcReq = 1; monEvt = 7'h7F;
    #1;
    chk("R1 req", int'(irqReq), 0);
    chk("R1 inService", int'(inService), 0);
    serReq = 0; ddcReq = 0; monEvt = '0;

    // Table of combinational resolution cases
    for (int k = 0; k < NVEC; k++) begin
      wrReg(0, VECS[k].en);
      wrReg(1, VECS[k].pr);
      monEvt = VECS[k].mon; serReq = VECS[k].ser; ddcReq = VECS[k].ddc;
      #1;
      chkReq($sformatf("R2-5,9 table %0d", k), VECS[k].expReq, VECS[k].expIdx);
    end
    monEvt = '0; serReq = 0; ddcReq = 0;
    wrReg(1, 8'h00);

    // R8 timer 0 pulse latched, acknowledged, handler returns
    wrReg(0, 8'h8A);
    tmr0Ovf = 1; tick(); tmr0Ovf = 0;
    chkReq("R8 tmr0 latched", 1, 3'd1);
    tick(3);
    chkReq("R8 tmr0 holds", 1, 3'd1);
    pulse(0);
    chk("R10 low in service", int'(inService), 1);
    chk("R8 tmr0 blocked", int'(irqReq), 0);
    pulse(1);
    chk("R11 low released", int'(inService), 0);
    chk("R8 tmr0 cleared", int'(irqReq), 0);
    tmr1Ovf = 1; tick(); tmr1Ovf = 0;
    chkReq("R8 tmr1 latched", 1, 3'd3);
    pulse(0); pulse(1);
    chk("R8 tmr1 cleared", int'(irqReq), 0);

    // R6 falling edge mode, R12 pin latency
    wrReg(0, 8'h81);
    wrReg(2, 8'h01);
    extPinN = 0;
    tick(2);
    chk("R12 pin not yet", int'(irqReq), 0);
    tick();
    chkReq("R12 pin third edge", 1, 3'd0);
    extPinN = 1;
    tick(4);
    chkReq("R6 edge flag holds", 1, 3'd0);
    pulse(0);
    chk("R6 ack in service", int'(inService), 1);
    pulse(1);
    chk("R6 ack cleared flag", int'(irqReq), 0);

    // R7 level mode
    wrReg(2, 8'h00);
    extPinN = 0;
    tick(3);
    chkReq("R7 level request", 1, 3'd0);
    pulse(0);
    pulse(1);
    chkReq("R7 ack kept flag", 1, 3'd0);
    extPinN = 1;
    tick(3);
    chk("R7 follows pin high", int'(irqReq), 0);

    // R10, R11 nesting
    wrReg(0, 8'hB0);
    wrReg(1, 8'h20);
    serReq = 1;
    #1;
    chkReq("R10 low presented", 1, 3'd4);
    pulse(0);
    chk("R10 low blocked", int'(irqReq), 0);
    ddcReq = 1;
    #1;
    chkReq("R10 high preempts", 1, 3'd5);
    pulse(0);
    chk("R10 both in service", int'(inService), 3);
    chk("R10 high busy silent", int'(irqReq), 0);
    pulse(1);
    chk("R11 high released first", int'(inService), 1);
    chkReq("R10 high again", 1, 3'd5);
    ddcReq = 0;
    #1;
    chk("R10 low still blocked", int'(irqReq), 0);
    pulse(1);
    chk("R11 low released", int'(inService), 0);
    chkReq("R10 low resumes", 1, 3'd4);
    serReq = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule